// File: doc/BRIEF.md
# CPU-Side Interrupt Acknowledge and Nesting Unit

This unit is the processor-facing half of an interrupt controller, for one CPU. Software reaches it through a small register window. The window holds an interface enable, a priority mask, an acknowledge register, an end-of-interrupt register, the running priority and the highest-pending ID. A priority selector elsewhere supplies the best pending ID for this CPU with its priority and its distribution model. The unit filters that candidate against the enable and the mask. It drives the CPU interrupt line. On an acknowledge it sends a pending-clear command back to the distributor state.

Nesting is kept as a linked list. Each acknowledge stores the previously running ID and priority in a link slot owned by the new ID. Completing the running ID pops the list. Completing an older, preempted ID removes it from the middle of the list. That removal walks the chain over several cycles, and while the walk runs the unit stalls all register accesses.

Register requests use a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The unit lowers `req_ready` only while a chain walk is running, and the requester must hold the request stable until it is taken. Every accepted read produces `rsp_valid` for one cycle, one cycle after acceptance, with the data in `rsp_data`. The response cannot be stalled. During an accepted end-of-interrupt write, `eoi_query_id` carries the written ID. The distributor must answer the four `eoi_*` attribute inputs for that ID in the same cycle.

Top module: `cpuif_ack_unit`

## Requirements
- R1: After reset, the control register reads 0, the mask reads 0xF0, the running priority reads 0x100, the highest-pending register reads 1023 and `irq_o` is low.
- R2: Register offsets are as follows.
  - 0x00: control, bit 0 enables the interface, read/write.
  - 0x04: priority mask, bits 7:0, read/write.
  - 0x08: binary point, reads 0 and ignores writes.
  - 0x0C: acknowledge, read.
  - 0x10: end-of-interrupt, write, ID in bits 9:0.
  - 0x14: running priority, read, 9 bits.
  - 0x18: highest-pending ID, read.
  - Any other offset reads 0.
- R3: The highest-pending register reads `pend_id` when three conditions hold: the interface is enabled, `pend_id` is not 1023, and `pend_prio` is at or below the mask. Otherwise it reads 1023.
- R4: `irq_o` is high exactly when the R3 candidate is visible and `pend_prio` is strictly below the running priority.
- R5: An acknowledge read returns 1023 and changes no state when `irq_o` would be low.
- R6: A successful acknowledge has these effects:
  - it returns `pend_id`;
  - that ID becomes running, with `pend_prio` as the running priority;
  - one cycle later it pulses `clr_valid` with `clr_id` equal to the ID;
  - `clr_all` equals `pend_one_of_n`, where 1 means clear for all CPUs and 0 means clear for this CPU only.
- R7: An end-of-interrupt write while the running ID is 1023 is ignored. No re-pend is issued and no state changes.
- R8: On any other end-of-interrupt write, one cycle later `repend_valid` pulses with `repend_id` equal to the written ID. This happens exactly when `eoi_edge_cfg` is 0 and `eoi_src_enabled`, `eoi_targets_cpu` and `eoi_line_high` are all 1.
- R9: Completing the running ID restores the ID and priority that were running when it was acknowledged. Restoring 1023 gives running priority 0x100.
- R10: Completing an older ID leaves the running ID and priority unchanged and removes that ID from the chain. A later pop skips it.
- R11: While a chain walk runs, `req_ready` is low, and it returns high when the walk ends.
- R12: Each accepted read gives `rsp_valid` high for exactly one cycle, one cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request can be taken (low during chain walk) |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 8 | Register offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 32 | Read data |
| pend_id | input | 10 | Best pending ID from the selector (1023 = none) |
| pend_prio | input | 8 | Priority of `pend_id` |
| pend_one_of_n | input | 1 | `pend_id` uses the 1-of-N model |
| eoi_query_id | output | 10 | ID whose attributes are needed at end-of-interrupt |
| eoi_edge_cfg | input | 1 | Queried ID is edge configured |
| eoi_src_enabled | input | 1 | Queried ID is enabled |
| eoi_targets_cpu | input | 1 | Queried ID targets this CPU |
| eoi_line_high | input | 1 | Queried ID's input is high |
| clr_valid | output | 1 | Pending-clear command |
| clr_id | output | 10 | ID to clear |
| clr_all | output | 1 | Clear for all CPUs |
| repend_valid | output | 1 | Re-pend command for this CPU |
| repend_id | output | 10 | ID to mark pending |
| irq_o | output | 1 | Interrupt request to the CPU |

## Verification
The bench sweeps the candidate priority across the mask range at several mask values. This catches an off-by-one in the at-or-below test, which would show a masked ID or hide one sitting exactly on the mask. A pending priority equal to the running priority must not be acknowledged; a design using a non-strict compare would nest an interrupt inside itself. All sixteen combinations of the re-pend attributes are driven at end-of-interrupt, so a wrongly decoded condition re-pends edge or untargeted interrupts. A three-deep chain is completed out of order, then popped. A design that fails to unlink an older ID would later restore a completed interrupt, and one that does not stall during the walk would accept a request mid-walk.

// File: rtl/cpuif_pkg.sv
package cpuif_pkg;
  localparam int ID_W = 10;
  localparam logic [ID_W-1:0] NO_ID = 10'd1023;
  localparam logic [8:0] IDLE_PRIO = 9'h100;
  localparam logic [7:0] MASK_RESET = 8'hF0;

  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_MASK = 8'h04;
  localparam logic [7:0] OFS_BINPT = 8'h08;
  localparam logic [7:0] OFS_ACK = 8'h0C;
  localparam logic [7:0] OFS_EOI = 8'h10;
  localparam logic [7:0] OFS_RUNPR = 8'h14;
  localparam logic [7:0] OFS_HIPEND = 8'h18;

  typedef enum logic {WALK_IDLE, WALK_RUN} walk_state_t;

  typedef struct packed {
    logic [ID_W-1:0] id;
    logic [8:0] prio;
  } link_t;
endpackage

// File: rtl/cpuif_pend_filter.sv
module cpuif_pend_filter
  import cpuif_pkg::*;
(
  input logic en,
  input logic [7:0] mask,
  input logic [ID_W-1:0] cand_id,
  input logic [7:0] cand_prio,
  input logic [8:0] run_prio,
  output logic [ID_W-1:0] vis_id,
  output logic can_preempt
);
  logic visible;
  always_comb begin
    visible = en && (cand_id != NO_ID) && (cand_prio <= mask);
    vis_id = visible ? cand_id : NO_ID;
    can_preempt = visible && ({1'b0, cand_prio} < run_prio);
  end
endmodule

// File: rtl/cpuif_nest_chain.sv
module cpuif_nest_chain
  import cpuif_pkg::*;
#(
  parameter int NIRQ = 64
) (
  input logic clk,
  input logic rst_n,
  input logic ack_go,
  input logic [ID_W-1:0] ack_id,
  input logic [8:0] ack_prio,
  input logic eoi_go,
  input logic [ID_W-1:0] eoi_id,
  output logic [ID_W-1:0] run_id,
  output logic [8:0] run_prio,
  output logic busy
);
  localparam int IW = (NIRQ > 1) ? $clog2(NIRQ) : 1;

  link_t slot [NIRQ];
  walk_state_t state;
  logic [ID_W-1:0] walk_ptr;
  logic [ID_W-1:0] walk_tgt;

  function automatic logic in_range(input logic [ID_W-1:0] id);
    return 32'(id) < NIRQ;
  endfunction

  function automatic logic [IW-1:0] ix(input logic [ID_W-1:0] id);
    return id[IW-1:0];
  endfunction

  link_t run_link, ptr_link, tgt_link;
  always_comb begin
    run_link = in_range(run_id) ? slot[ix(run_id)] : '{id: NO_ID, prio: IDLE_PRIO};
    ptr_link = in_range(walk_ptr) ? slot[ix(walk_ptr)] : '{id: NO_ID, prio: IDLE_PRIO};
    tgt_link = in_range(walk_tgt) ? slot[ix(walk_tgt)] : '{id: NO_ID, prio: IDLE_PRIO};
  end

  assign busy = (state == WALK_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_id <= NO_ID;
      run_prio <= IDLE_PRIO;
      state <= WALK_IDLE;
      walk_ptr <= NO_ID;
      walk_tgt <= NO_ID;
      for (int i = 0; i < NIRQ; i++) slot[i] <= '{id: NO_ID, prio: IDLE_PRIO};
    end else if (state == WALK_RUN) begin
      if (ptr_link.id == NO_ID) begin
        state <= WALK_IDLE;
      end else if (ptr_link.id == walk_tgt) begin
        if (in_range(walk_ptr)) slot[ix(walk_ptr)] <= tgt_link;
        state <= WALK_IDLE;
      end else begin
        walk_ptr <= ptr_link.id;
      end
    end else if (ack_go) begin
      if (in_range(ack_id)) slot[ix(ack_id)] <= '{id: run_id, prio: run_prio};
      run_id <= ack_id;
      run_prio <= ack_prio;
    end else if (eoi_go) begin
      if (eoi_id == run_id) begin
        run_id <= run_link.id;
        run_prio <= (run_link.id == NO_ID) ? IDLE_PRIO : run_link.prio;
      end else begin
        walk_ptr <= run_id;
        walk_tgt <= eoi_id;
        state <= WALK_RUN;
      end
    end
  end
endmodule

// File: rtl/cpuif_ack_unit.sv
module cpuif_ack_unit
  import cpuif_pkg::*;
#(
  parameter int NIRQ = 64
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  output logic req_ready,
  input logic req_write,
  input logic [7:0] req_addr,
  input logic [31:0] req_wdata,
  output logic rsp_valid,
  output logic [31:0] rsp_data,
  input logic [9:0] pend_id,
  input logic [7:0] pend_prio,
  input logic pend_one_of_n,
  output logic [9:0] eoi_query_id,
  input logic eoi_edge_cfg,
  input logic eoi_src_enabled,
  input logic eoi_targets_cpu,
  input logic eoi_line_high,
  output logic clr_valid,
  output logic [9:0] clr_id,
  output logic clr_all,
  output logic repend_valid,
  output logic [9:0] repend_id,
  output logic irq_o
);
  logic ctl_en;
  logic [7:0] prio_mask;
  logic [ID_W-1:0] run_id, vis_id;
  logic [8:0] run_prio;
  logic chain_busy, can_preempt;
  logic take, take_rd, take_wr, ack_go, eoi_go;

  cpuif_pend_filter u_filt (
    .en(ctl_en), .mask(prio_mask), .cand_id(pend_id), .cand_prio(pend_prio),
    .run_prio(run_prio), .vis_id(vis_id), .can_preempt(can_preempt)
  );

  assign req_ready = !chain_busy;
  assign take = req_valid && req_ready;
  assign take_rd = take && !req_write;
  assign take_wr = take && req_write;
  assign ack_go = take_rd && (req_addr == OFS_ACK) && can_preempt;
  assign eoi_go = take_wr && (req_addr == OFS_EOI) && (run_id != NO_ID);
  assign eoi_query_id = req_wdata[ID_W-1:0];
  assign irq_o = can_preempt;

  cpuif_nest_chain #(.NIRQ(NIRQ)) u_chain (
    .clk(clk), .rst_n(rst_n), .ack_go(ack_go), .ack_id(pend_id),
    .ack_prio({1'b0, pend_prio}), .eoi_go(eoi_go), .eoi_id(req_wdata[ID_W-1:0]),
    .run_id(run_id), .run_prio(run_prio), .busy(chain_busy)
  );

  logic [31:0] rd_mux;
  always_comb begin
    case (req_addr)
      OFS_CTRL: rd_mux = {31'd0, ctl_en};
      OFS_MASK: rd_mux = {24'd0, prio_mask};
      OFS_ACK: rd_mux = {22'd0, can_preempt ? pend_id : NO_ID};
      OFS_RUNPR: rd_mux = {23'd0, run_prio};
      OFS_HIPEND: rd_mux = {22'd0, vis_id};
      default: rd_mux = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_en <= 1'b0;
      prio_mask <= MASK_RESET;
      rsp_valid <= 1'b0;
      rsp_data <= 32'd0;
      clr_valid <= 1'b0;
      clr_id <= NO_ID;
      clr_all <= 1'b0;
      repend_valid <= 1'b0;
      repend_id <= NO_ID;
    end else begin
      rsp_valid <= take_rd;
      if (take_rd) rsp_data <= rd_mux;
      clr_valid <= ack_go;
      if (ack_go) begin
        clr_id <= pend_id;
        clr_all <= pend_one_of_n;
      end
      repend_valid <= eoi_go && !eoi_edge_cfg && eoi_src_enabled
                      && eoi_targets_cpu && eoi_line_high;
      if (eoi_go) repend_id <= req_wdata[ID_W-1:0];
      if (take_wr && req_addr == OFS_CTRL) ctl_en <= req_wdata[0];
      if (take_wr && req_addr == OFS_MASK) prio_mask <= req_wdata[7:0];
    end
  end
endmodule

// File: rtl/cpuif_ack_unit_chk.sv
module cpuif_ack_unit_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic req_write,
  input logic rsp_valid,
  input logic busy,
  input logic [9:0] run_id,
  input logic [8:0] run_prio,
  input logic clr_valid,
  input logic [9:0] clr_id,
  input logic irq_o,
  input logic ctl_en
);
  assert_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);
  assert_rsp_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> rsp_valid);
  assert_rsp_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready && !req_write) |=> !rsp_valid);
  assert_clr_running_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_valid |-> (run_id == clr_id));
  assert_idle_prio_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run_id == 10'd1023) |-> (run_prio == 9'h100));
  assert_irq_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ctl_en);
endmodule

bind cpuif_ack_unit cpuif_ack_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .rsp_valid(rsp_valid), .busy(chain_busy),
  .run_id(run_id), .run_prio(run_prio), .clr_valid(clr_valid), .clr_id(clr_id),
  .irq_o(irq_o), .ctl_en(ctl_en)
);

// File: tb/cpuif_ack_unit_test.sv
module cpuif_ack_unit_test;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [7:0] req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic req_ready, rsp_valid;
  logic [31:0] rsp_data;
  logic [9:0] pend_id = 10'd1023;
  logic [7:0] pend_prio = 8'hFF;
  logic pend_one_of_n = 0;
  logic [9:0] eoi_query_id;
  logic eoi_edge_cfg = 0, eoi_src_enabled = 0, eoi_targets_cpu = 0, eoi_line_high = 0;
  logic clr_valid, clr_all, repend_valid, irq_o;
  logic [9:0] clr_id, repend_id;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [31:0] rd;
  logic cap_clr, cap_all, cap_rep;
  logic [9:0] cap_clr_id, cap_rep_id;

  always #2 clk = ~clk;

  cpuif_ack_unit #(.NIRQ(16)) uut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    rd = rsp_data;
    cap_clr = clr_valid; cap_clr_id = clr_id; cap_all = clr_all;
    cap_rep = repend_valid; cap_rep_id = repend_id;
    if (!wr) check("R12 rsp_valid", {31'd0, rsp_valid}, 32'd1);
  endtask

  task automatic ack_as(input logic [9:0] id, input logic [7:0] pr, input logic m,
                        input logic [9:0] exp_id, input string tag);
    pend_id = id; pend_prio = pr; pend_one_of_n = m;
    access(0, 8'h0C, 0);
    check(tag, rd, {22'd0, exp_id});
    pend_id = 10'd1023; pend_prio = 8'hFF;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [7:0] masks [4];
    masks = '{8'h00, 8'h80, 8'hF0, 8'hFF};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", {31'd0, irq_o}, 0);
    access(0, 8'h00, 0); check("R1 ctrl", rd, 0);
    access(0, 8'h04, 0); check("R1 mask", rd, 32'hF0);
    access(0, 8'h14, 0); check("R1 runprio", rd, 32'h100);
    access(0, 8'h18, 0); check("R1 hipend", rd, 32'd1023);
    // R2 map
    access(1, 8'h08, 32'hFF); access(0, 8'h08, 0); check("R2 binpt", rd, 0);
    access(0, 8'h1C, 0); check("R2 unmapped", rd, 0);
    access(1, 8'h04, 32'h1234_5A6B); access(0, 8'h04, 0); check("R2 mask rw", rd, 32'h6B);
    access(1, 8'h00, 32'h3); access(0, 8'h00, 0); check("R2 ctrl rw", rd, 1);
    // R3/R4 sweep with nothing running
    for (int mi = 0; mi < 4; mi++) begin
      access(1, 8'h04, {24'd0, masks[mi]});
      for (int p = 0; p < 256; p += 15) begin
        pend_id = 10'd6; pend_prio = 8'(p);
        access(0, 8'h18, 0);
        check("R3 hipend sweep", rd, (p <= masks[mi]) ? 32'd6 : 32'd1023);
        check("R4 irq sweep", {31'd0, irq_o}, (p <= masks[mi]) ? 1 : 0);
      end
    end
    pend_id = 10'd1023; access(0, 8'h18, 0); check("R3 no candidate", rd, 32'd1023);
    pend_id = 10'd6; pend_prio = 8'h10;
    access(1, 8'h00, 0); access(0, 8'h18, 0); check("R3 disabled", rd, 32'd1023);
    check("R4 disabled irq", {31'd0, irq_o}, 0);
    ack_as(10'd6, 8'h10, 0, 10'd1023, "R5 ack while disabled");
    access(0, 8'h14, 0); check("R5 no change", rd, 32'h100);
    access(1, 8'h00, 1); access(1, 8'h04, 32'hFF);
    // R7 EOI while idle
    eoi_edge_cfg = 0; eoi_src_enabled = 1; eoi_targets_cpu = 1; eoi_line_high = 1;
    access(1, 8'h10, 32'd6);
    check("R7 no repend", {31'd0, cap_rep}, 0);
    access(0, 8'h14, 0); check("R7 runprio", rd, 32'h100);
    // R6 nested acks
    ack_as(10'd5, 8'h80, 1, 10'd5, "R6 ack 5");
    check("R6 clr", {21'd0, cap_clr, cap_all, cap_clr_id}, {21'd0, 1'b1, 1'b1, 10'd5});
    access(0, 8'h14, 0); check("R6 runprio 5", rd, 32'h80);
    ack_as(10'd7, 8'h40, 0, 10'd7, "R6 ack 7");
    check("R6 clr cpu only", {21'd0, cap_clr, cap_all, cap_clr_id}, {21'd0, 1'b1, 1'b0, 10'd7});
    ack_as(10'd9, 8'h10, 0, 10'd9, "R6 ack 9");
    pend_id = 10'd3; pend_prio = 8'h10;
    @(negedge clk); check("R4 equal prio no irq", {31'd0, irq_o}, 0);
    ack_as(10'd3, 8'h10, 0, 10'd1023, "R5 equal prio");
    check("R5 no clr", {31'd0, cap_clr}, 0);
    access(0, 8'h14, 0); check("R5 runprio kept", rd, 32'h10);
    // R10/R11 complete older ID 7
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 8'h10; req_wdata = 32'd7;
    @(negedge clk); req_valid = 0;
    check("R8 repend older", {21'd0, repend_valid, repend_id}, {21'd0, 1'b1, 10'd7});
    check("R11 stalled", {31'd0, req_ready}, 0);
    access(0, 8'h14, 0); check("R10 running kept", rd, 32'h10);
    check("R11 ready again", {31'd0, req_ready}, 1);
    // R9 pop 9 -> 5 (7 skipped)
    eoi_edge_cfg = 1;
    access(1, 8'h10, 32'd9); check("R8 edge no repend", {31'd0, cap_rep}, 0);
    access(0, 8'h14, 0); check("R10 skip unlinked", rd, 32'h80);
    access(1, 8'h10, 32'd5);
    access(0, 8'h14, 0); check("R9 back to idle", rd, 32'h100);
    // R8 exhaustive attribute combinations
    for (int c = 0; c < 16; c++) begin
      ack_as(10'd2, 8'h20, 0, 10'd2, "R6 ack 2");
      {eoi_edge_cfg, eoi_src_enabled, eoi_targets_cpu, eoi_line_high} = 4'(c);
      access(1, 8'h10, 32'd2);
      check("R8 repend combo", {21'd0, cap_rep, cap_rep ? cap_rep_id : 10'd0},
            (c == 7) ? {21'd0, 1'b1, 10'd2} : 32'd0);
      access(0, 8'h14, 0); check("R9 pop combo", rd, 32'h100);
    end
    finish_run();
  end
endmodule